// File: doc/BRIEF.md
# Double-Buffered PWM Timer

This block generates one pulse-width-modulated output from a free-running up-counter. An internal prescaler advances the counter once every `DIV` clocks (four by default). The counter clears after it reaches a programmable period value, and that clear starts a new PWM cycle. The output is held in a set/reset flop. It is set at the start of each cycle and cleared when the count reaches the active duty value. Because set and reset are separate events, a missed event can never leave the high and low phases swapped.

Software loads the duty value through a write strobe. In double-buffer mode the value lands in a shadow register and becomes active only at the next counter clear. A duty change at any point in the cycle therefore yields a clean waveform, even when it swings between the always-low and always-high extremes. Single-buffer mode applies a write at once. It stays selectable for uses that tolerate a skipped pulse. A one-clock interrupt pulse marks every cycle boundary.

The block carries no data stream, so there is no valid/ready pair. The write strobes are accepted on every clock and cannot apply back-pressure. The enable, the mode bit and the outputs are plain level pins.

Top module: `pwm_dbuf_timer`

## Requirements
- R1: While reset is asserted and on the first clock after it, `pwm_o` and `irq_o` are 0. Reset loads the period with all ones and the duty with 0.
- R2: With `en` high, the counter advances on every `DIV`-th clock. The first advance comes `DIV` clocks after `en` rises, so one PWM cycle lasts (period+1)*`DIV` clocks.
- R3: On a prescale tick where the count is greater than or equal to the period, the counter returns to 0. In that same clock `irq_o` pulses high for exactly one clock.
- R4: `pwm_o` goes high at each counter clear and on the clock after `en` rises (unless the active duty is 0). It goes low on the tick where the count becomes equal to the duty in effect. When set and reset coincide, reset wins, so a duty of 0 holds the output low.
- R5: A duty value greater than the period never matches, so the output stays high for the whole cycle.
- R6: With `dbuf_mode`=1, a duty write goes only to the shadow register. The active duty changes only at a counter clear, taking the shadow value held before that clock. A write in the middle of a cycle does not alter that cycle.
- R7: With `dbuf_mode`=0, a duty write becomes active on the next clock. A write below the current count therefore skips the low phase of that cycle.
- R8: With `en` low, the counter and prescaler are held at 0, `pwm_o` goes low on the next clock and no interrupt is issued. The active duty is reloaded from the shadow (or from a same-clock write), so the first cycle after enabling uses the latest written duty.
- R9: In double-buffer mode, alternating the duty between 0 and a value above the period gives whole cycles of constant low and constant high, each starting exactly at a counter clear.
- R10: A period write takes effect on the next clock. If the new period is at or below the current count, the counter clears on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low stops the counter and forces the output low |
| dbuf_mode | input | 1 | 1 = duty writes via shadow register, 0 = immediate |
| period_we | input | 1 | Period write strobe |
| period_wdata | input | CW | Period value (count at which the counter clears) |
| duty_we | input | 1 | Duty write strobe |
| duty_wdata | input | CW | Duty value (count at which the output resets) |
| pwm_o | output | 1 | PWM output |
| irq_o | output | 1 | One-clock pulse at each counter clear |

## Verification
The assertions check on every clock the properties that follow from local events. The output may rise only at a cycle start and fall only on a duty match or a disable. The interrupt is one clock wide and coincides with a zero count. The active duty holds still between clears in double-buffer mode. Disable silences both outputs. Effects that span a whole cycle can only be shown by the bench scenarios. These are the skipped low phase of an immediate write, a mid-cycle write deferred to the next cycle, high/low extreme swings, the duty picked up on re-enable, and a period cut below the running count. The bench measures these as high-time and interrupt spacing.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;
  // Events produced per clock by the counting path.
  typedef struct packed {
    logic tick;   // prescaled advance
    logic wrap;   // counter clear / cycle start
    logic start;  // first clock after enable rises
  } pwm_evt_t;
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  generate
    if (DIV > 1) begin : g_div
      localparam int DW = $clog2(DIV);
      localparam logic [DW-1:0] LAST = DW'(DIV - 1);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk) begin
        if (!rst_n || !en)   div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                 div_q <= div_q + 1'b1;
      end
      assign tick = en && (div_q == LAST);
    end else begin : g_nodiv
      assign tick = en;
    end
  endgenerate
endmodule

// File: rtl/pwm_count.sv
module pwm_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic [CW-1:0] period,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_nxt,
  output logic          wrap
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  always_comb begin
    wrap    = tick && (cnt_q >= period);
    cnt_nxt = wrap ? '0 : cnt_q + ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) cnt_q <= '0;
    else if (tick)     cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/pwm_duty_buf.sv
module pwm_duty_buf #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          dbuf_mode,
  input  logic          duty_we,
  input  logic [CW-1:0] duty_wdata,
  input  logic          wrap,
  output logic [CW-1:0] duty_act,
  output logic [CW-1:0] duty_eff
);
  logic [CW-1:0] shadow_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       shadow_q <= '0;
    else if (duty_we) shadow_q <= duty_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     duty_act <= '0;
    else if (!en)                   duty_act <= duty_we ? duty_wdata : shadow_q;
    else if (!dbuf_mode && duty_we) duty_act <= duty_wdata;
    else if (dbuf_mode && wrap)     duty_act <= shadow_q;
  end

  // Value compared on this clock: at a buffered clear the new cycle
  // already uses the shadow value.
  assign duty_eff = (dbuf_mode && wrap) ? shadow_q : duty_act;
endmodule

// File: rtl/pwm_sr_out.sv
module pwm_sr_out
  import pwm_dbuf_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  pwm_evt_t      evt,
  input  logic [CW-1:0] cnt_nxt,
  input  logic [CW-1:0] duty_eff,
  input  logic [CW-1:0] duty_act,
  output logic          match,
  output logic          pwm_o,
  output logic          irq_o
);
  logic set_ev;

  always_comb begin
    match  = evt.tick && (cnt_nxt == duty_eff);
    set_ev = evt.wrap || (evt.start && (duty_act != '0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) pwm_o <= 1'b0;
    else if (match)    pwm_o <= 1'b0;   // reset dominates
    else if (set_ev)   pwm_o <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= en && evt.wrap;
  end
endmodule

// File: rtl/pwm_dbuf_timer.sv
module pwm_dbuf_timer
  import pwm_dbuf_pkg::*;
#(
  parameter int CW  = 16,
  parameter int DIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          dbuf_mode,
  input  logic          period_we,
  input  logic [CW-1:0] period_wdata,
  input  logic          duty_we,
  input  logic [CW-1:0] duty_wdata,
  output logic          pwm_o,
  output logic          irq_o
);
  logic          tick;
  logic          wrap;
  logic          start;
  logic          match;
  logic          en_q;
  logic [CW-1:0] period_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;
  logic [CW-1:0] duty_act;
  logic [CW-1:0] duty_eff;
  pwm_evt_t      evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      period_q <= '1;
    end else begin
      en_q <= en;
      if (period_we) period_q <= period_wdata;
    end
  end

  assign start = en && !en_q;

  always_comb begin
    evt.tick  = tick;
    evt.wrap  = wrap;
    evt.start = start;
  end

  pwm_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick)
  );

  pwm_count #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .period(period_q),
    .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .wrap(wrap)
  );

  pwm_duty_buf #(.CW(CW)) u_duty (
    .clk(clk), .rst_n(rst_n), .en(en), .dbuf_mode(dbuf_mode),
    .duty_we(duty_we), .duty_wdata(duty_wdata), .wrap(wrap),
    .duty_act(duty_act), .duty_eff(duty_eff)
  );

  pwm_sr_out #(.CW(CW)) u_out (
    .clk(clk), .rst_n(rst_n), .en(en), .evt(evt), .cnt_nxt(cnt_nxt),
    .duty_eff(duty_eff), .duty_act(duty_act), .match(match),
    .pwm_o(pwm_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/pwm_dbuf_timer_chk.sv
module pwm_dbuf_timer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          dbuf_mode,
  input logic          pwm_o,
  input logic          irq_o,
  input logic [CW-1:0] cnt_q,
  input logic          wrap,
  input logic          start,
  input logic          match,
  input logic [CW-1:0] duty_act
);
  // R8: disable forces the output low on the next clock
  a_r8_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pwm_o);

  // R8: no interrupt while disabled
  a_r8_no_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !irq_o);

  // R3: interrupt marks a counter that has just returned to zero
  a_r3_irq_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (cnt_q == '0));

  // R3: interrupt is a single-clock pulse
  a_r3_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  // R4: output only rises at a cycle start
  a_r4_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_o) |-> $past(wrap || start));

  // R4: output only falls on a duty match or a disable
  a_r4_fall_at_match: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwm_o) |-> $past(match || !en));

  // R6: buffered active duty holds between counter clears
  a_r6_hold_active: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dbuf_mode && !wrap) |=> $stable(duty_act));
endmodule

bind pwm_dbuf_timer pwm_dbuf_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .dbuf_mode(dbuf_mode),
  .pwm_o(pwm_o), .irq_o(irq_o), .cnt_q(cnt_q), .wrap(wrap),
  .start(start), .match(match), .duty_act(duty_act)
);

// File: tb/tb_pwm_dbuf_timer.sv
`timescale 1ns/1ps
module tb_pwm_dbuf_timer;
  localparam int CW  = 16;
  localparam int DIV = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic          dbuf_mode = 1'b1;
  logic          period_we = 1'b0;
  logic [CW-1:0] period_wdata = '0;
  logic          duty_we = 1'b0;
  logic [CW-1:0] duty_wdata = '0;
  logic          pwm_o;
  logic          irq_o;

  always #2 clk = ~clk;   // 250 MHz

  pwm_dbuf_timer #(.CW(CW), .DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .dbuf_mode(dbuf_mode),
    .period_we(period_we), .period_wdata(period_wdata),
    .duty_we(duty_we), .duty_wdata(duty_wdata),
    .pwm_o(pwm_o), .irq_o(irq_o)
  );

  int    vectors = 0;
  int    errors  = 0;
  string cur_req = "R1";

  // Behavioural reference, one update per clock edge.
  int m_div, m_cnt, m_per, m_shadow, m_act;
  bit m_pwm, m_irq, m_enq;

  always @(posedge clk) begin
    int tk, wr, st, eff, nx, mt;
    if (!rst_n) begin
      m_div = 0; m_cnt = 0; m_per = (1 << CW) - 1; m_shadow = 0; m_act = 0;
      m_pwm = 0; m_irq = 0; m_enq = 0;
    end else begin
      tk  = (en && m_div == DIV - 1) ? 1 : 0;
      wr  = (tk && m_cnt >= m_per) ? 1 : 0;
      st  = (en && !m_enq) ? 1 : 0;
      eff = (dbuf_mode && wr) ? m_shadow : m_act;
      nx  = wr ? 0 : m_cnt + 1;
      mt  = (tk && nx == eff) ? 1 : 0;
      if (!en)                   m_pwm = 0;
      else if (mt != 0)          m_pwm = 0;
      else if (wr != 0)          m_pwm = 1;
      else if (st != 0 && m_act != 0) m_pwm = 1;
      m_irq = (en && wr != 0);
      if (!en)          m_act = duty_we ? int'(duty_wdata) : m_shadow;
      else if (!dbuf_mode && duty_we) m_act = int'(duty_wdata);
      else if (dbuf_mode && wr != 0)  m_act = m_shadow;
      if (duty_we)   m_shadow = int'(duty_wdata);
      if (period_we) m_per = int'(period_wdata);
      if (!en)             m_cnt = 0;
      else if (tk != 0)    m_cnt = nx;
      if (!en || m_div == DIV - 1) m_div = 0;
      else                 m_div = m_div + 1;
      m_enq = en;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      vectors++;
      if (pwm_o !== m_pwm || irq_o !== m_irq) begin
        errors++;
        $display("FAIL %s: pwm_o=%b irq_o=%b expected pwm=%0d irq=%0d at %0t",
                 cur_req, pwm_o, irq_o, m_pwm, m_irq, $time);
      end
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_cnt(input int n, output int hi, output int iq);
    hi = 0; iq = 0;
    for (int i = 0; i < n; i++) begin
      step(1);
      if (pwm_o) hi++;
      if (irq_o) iq++;
    end
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    for (int i = 0; i < 2000; i++) begin
      step(1);
      n++;
      if (irq_o) break;
    end
  endtask

  task automatic set_duty(input int v);
    duty_we = 1'b1; duty_wdata = CW'(v);
  endtask

  task automatic set_period(input int v);
    period_we = 1'b1; period_wdata = CW'(v);
    step(1);
    period_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int h, q, n, hs, qs;
    // R1: reset state
    cur_req = "R1";
    step(3);
    chk("R1 pwm in reset", int'(pwm_o), 0);
    chk("R1 irq in reset", int'(irq_o), 0);
    rst_n = 1'b1;
    step(1);
    chk("R1 pwm after reset", int'(pwm_o), 0);

    // R2/R3/R4: buffered, period 9, duty 4
    cur_req = "R2";
    dbuf_mode = 1'b1;
    set_period(9);
    set_duty(4); step(1); duty_we = 1'b0;
    en = 1'b1;
    hs = 0; qs = 0; n = 0;
    for (int i = 1; i <= 120; i++) begin
      step(1);
      if (pwm_o) hs++;
      if (irq_o) begin qs++; if (n == 0) n = i; end
    end
    chk("R2 first clear after (P+1)*DIV clocks", n, 40);
    chk("R3 interrupts in three cycles", qs, 3);
    chk("R4 high clocks at duty 4", hs, 48);

    // R6: mid-cycle write deferred to next cycle
    cur_req = "R6";
    wait_irq(n);
    hs = int'(pwm_o);
    run_cnt(4, h, q); hs += h;
    set_duty(8); run_cnt(1, h, q); hs += h; duty_we = 1'b0;
    run_cnt(34, h, q); hs += h;
    chk("R6 current cycle keeps old duty", hs, 16);
    run_cnt(40, h, q);
    chk("R6 next cycle uses new duty", h + int'(pwm_o) - int'(pwm_o), 32);

    // R7: immediate write skips low phase
    cur_req = "R7";
    dbuf_mode = 1'b0;
    set_duty(4); step(1); duty_we = 1'b0;
    wait_irq(n);
    wait_irq(n);
    hs = int'(pwm_o);
    run_cnt(12, h, q); hs += h;
    set_duty(1); run_cnt(1, h, q); hs += h; duty_we = 1'b0;
    run_cnt(26, h, q); hs += h;
    chk("R7 skipped low phase", hs, 40);
    run_cnt(40, h, q);
    chk("R7 new duty active", h, 4);

    // R9/R5: extremes in buffered mode, period 5
    cur_req = "R9";
    dbuf_mode = 1'b1;
    set_period(5);
    wait_irq(n);
    run_cnt(8, h, q);
    set_duty(30); step(1); duty_we = 1'b0;
    wait_irq(n);
    hs = int'(pwm_o);
    run_cnt(9, h, q); hs += h;
    set_duty(0); run_cnt(1, h, q); hs += h; duty_we = 1'b0;
    run_cnt(13, h, q); hs += h;
    chk("R5 duty above period stays high", hs, 24);
    wait_irq(n);
    hs = int'(pwm_o);
    run_cnt(9, h, q); hs += h;
    set_duty(30); run_cnt(1, h, q); hs += h; duty_we = 1'b0;
    run_cnt(13, h, q); hs += h;
    chk("R9 duty 0 stays low", hs, 0);
    wait_irq(n);
    hs = int'(pwm_o);
    run_cnt(23, h, q); hs += h;
    chk("R9 back to constant high", hs, 24);

    // R8: disable, write while off, re-enable
    cur_req = "R8";
    run_cnt(5, h, q);
    en = 1'b0;
    step(1);
    chk("R8 output low after disable", int'(pwm_o), 0);
    set_period(9);
    set_duty(2); step(1); duty_we = 1'b0;
    run_cnt(40, h, q);
    chk("R8 no interrupt while off", q, 0);
    chk("R8 output held low while off", h, 0);
    en = 1'b1;
    run_cnt(40, h, q);
    chk("R8 re-enable uses latest duty", h, 8);

    // R10: period cut below running count
    cur_req = "R10";
    set_duty(4); step(1); duty_we = 1'b0;
    wait_irq(n);
    run_cnt(29, h, q);
    period_we = 1'b1; period_wdata = CW'(3);
    step(1);
    period_we = 1'b0;
    wait_irq(n);
    chk("R10 clear on next tick", 30 + n, 32);
    run_cnt(40, h, q);
    chk("R10 short period interrupt count", q, 2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule